// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver

This block is the receiving half of a slave on a two-wire serial bus. A fast system clock oversamples the bus. The clock line and the data line each pass through a short synchroniser. Bus conditions are then recognised on the synchronised copies:

- A start condition is the data line falling while the clock line is high.
- A stop condition is the data line rising while the clock line is high.

After a start, the block shifts in a nine-bit address packet. The packet holds seven address bits, most significant first, then a direction bit, then the acknowledge slot. The address is compared with a programmable own address.

The block answers the all-zero general call address when `gc_en` is set, but only for write transfers. It never answers addresses whose upper four bits are all ones. When the address is accepted, the block pulls the data line low in the acknowledge slot through an open-drain enable. It then takes in write bytes and acknowledges each one. Each accepted byte is presented on `rx_data` with a one-cycle `rx_valid` strobe.

A `busy` input from the local logic makes the block refuse the packet being acknowledged, whether it is an address or a data byte. Repeated starts and stops abandon whatever transfer is in progress. The block does not transmit read data, stretch the clock, decode ten-bit addresses or arbitrate.

Top module: `tw_slave_rx`

## Requirements
- R1: `scl_in` and `sda_in` pass through a synchroniser before any decision is made. A start condition (data line falling while the clock line is high) begins address reception. Data bits are sampled on clock-line rising edges, most significant bit first.
- R2: The address packet carries 7 address bits, then a direction bit (1 = read, 0 = write), then an acknowledge slot. An address equal to `own_addr` with the write bit is acknowledged, `addressed` goes high and `xfer_rd` stays low.
- R3: An address that matches neither `own_addr` nor an enabled general call is refused (data line left high). No byte is delivered and no acknowledge is driven until the next start.
- R4: `sda_oe` is low while address and data bits are transferred. It rises after the clock falling edge that ends the eighth bit and falls after the clock falling edge that ends the ninth bit.
- R5: Write data bytes arrive MSB first and each one is acknowledged. For each accepted byte, `rx_valid` pulses for one cycle with the byte on `rx_data`.
- R6: Address 0000000 with the write bit is acknowledged and sets `gc_sel` only when `gc_en` is 1; the following bytes are then delivered. With `gc_en` at 0 that address is refused.
- R7: Address 0000000 with the read bit is refused even when `gc_en` is 1.
- R8: An address whose upper four bits are 1111 is never acknowledged, even when `own_addr` equals it.
- R9: When `busy` is 1 at the acknowledge decision, the packet is refused. For a data byte, `rx_valid` does not pulse, and the rest of the transfer is ignored until the next start or stop.
- R10: An own address with the read bit is acknowledged and sets `xfer_rd`. The later packets of that transfer are neither acknowledged nor delivered.
- R11: A repeated start in the middle of a transfer abandons it, clears `addressed`, and restarts address reception.
- R12: A stop returns the block to idle, with `addressed` and `sda_oe` low.
- R13: After reset, `sda_oe`, `rx_valid`, `addressed`, `xfer_rd` and `gc_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| own_addr | input | 7 | Programmable slave address |
| gc_en | input | 1 | Allow the general call address for writes |
| busy | input | 1 | Local logic cannot accept; forces refusal |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| rx_data | output | 8 | Last accepted write byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte on rx_data |
| addressed | output | 1 | The block accepted the current address |
| xfer_rd | output | 1 | Accepted transfer is a read |
| gc_sel | output | 1 | Accepted transfer is a general call |

## Verification
The hardest situations to reach from the ports are conditions that arrive in the middle of a byte: a repeated start or a stop after only a few bits of a data packet. The bench reaches them with a single-bit driving task that can be stopped at any bit count. It then checks that the next address packet is decoded from a clean bit count. A second hard case is `busy` rising between an accepted address and the following data byte. The bench raises it between packets, then shows that this byte and the next are both refused and that no `rx_valid` strobe appears.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_AW = 7;
  localparam int TW_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } tw_state_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } tw_evt_t;
endpackage

// File: rtl/tw_sync_det.sv
module tw_sync_det
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_in,
  input  logic    sda_in,
  output tw_evt_t evt
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else begin
        scl_pipe[g] <= scl_pipe[g-1];
        sda_pipe[g] <= sda_pipe[g-1];
      end
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.scl_rise = scl_s & ~scl_q;
    evt.scl_fall = ~scl_s & scl_q;
    evt.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    evt.sda      = sda_s;
  end
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match
  import tw_pkg::*;
(
  input  logic [TW_DW-1:0] pkt,
  input  logic [TW_AW-1:0] own_addr,
  input  logic             gc_en,
  output logic             hit_own,
  output logic             hit_gc
);
  localparam logic [3:0] RSV_TOP = 4'hF;
  logic [TW_AW-1:0] addr;
  logic             is_rd, reserved, is_zero;

  assign addr     = pkt[TW_DW-1:1];
  assign is_rd    = pkt[0];
  assign reserved = (addr[TW_AW-1:TW_AW-4] == RSV_TOP);
  assign is_zero  = (addr == '0);
  assign hit_own  = (addr == own_addr) && !reserved && !is_zero;
  assign hit_gc   = gc_en && is_zero && !is_rd;
endmodule

// File: rtl/tw_rx_ctrl.sv
module tw_rx_ctrl
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  tw_evt_t          evt,
  input  logic             hit_own,
  input  logic             hit_gc,
  input  logic             busy,
  output logic [TW_DW-1:0] pkt,
  output logic             sda_oe,
  output logic [TW_DW-1:0] rx_data,
  output logic             rx_valid,
  output logic             addressed,
  output logic             xfer_rd,
  output logic             gc_sel
);
  localparam int CW = $clog2(TW_DW + 2);
  localparam logic [CW-1:0] LAST = CW'(TW_DW);

  tw_state_t      state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pkt       <= '0;
      sda_oe    <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      addressed <= 1'b0;
      xfer_rd   <= 1'b0;
      gc_sel    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (evt.stop) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        addressed <= 1'b0;
        xfer_rd   <= 1'b0;
        gc_sel    <= 1'b0;
      end else if (evt.start) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        addressed <= 1'b0;
        xfer_rd   <= 1'b0;
        gc_sel    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (evt.scl_rise && cnt != LAST) begin
              pkt <= {pkt[TW_DW-2:0], evt.sda};
              cnt <= cnt + 1'b1;
            end else if (evt.scl_fall && cnt == LAST) begin
              if (state == ST_ADDR) begin
                if ((hit_own || hit_gc) && !busy) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_AACK;
                  addressed <= 1'b1;
                  xfer_rd   <= pkt[0];
                  gc_sel    <= hit_gc;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                if (!busy) begin
                  sda_oe   <= 1'b1;
                  state    <= ST_DACK;
                  rx_data  <= pkt;
                  rx_valid <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end
            end
          end
          ST_AACK: begin
            if (evt.scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= xfer_rd ? ST_SKIP : ST_DATA;
            end
          end
          ST_DACK: begin
            if (evt.scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(evt.scl_fall));
  // R9
  busy_blocks_byte_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(busy));
  // R10
  no_byte_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !xfer_rd);
  // R11
  start_releases_chk: assert property (@(posedge clk) disable iff (rst)
    evt.start |=> (!sda_oe && !addressed));
  // R12
  stop_idles_chk: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> (!sda_oe && !addressed && !gc_sel));
endmodule

// File: rtl/tw_slave_rx.sv
module tw_slave_rx
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [TW_AW-1:0] own_addr,
  input  logic             gc_en,
  input  logic             busy,
  output logic             sda_oe,
  output logic [TW_DW-1:0] rx_data,
  output logic             rx_valid,
  output logic             addressed,
  output logic             xfer_rd,
  output logic             gc_sel
);
  tw_evt_t          evt;
  logic [TW_DW-1:0] pkt;
  logic             hit_own, hit_gc;

  tw_sync_det #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .evt(evt)
  );

  tw_addr_match u_match (
    .pkt(pkt), .own_addr(own_addr), .gc_en(gc_en),
    .hit_own(hit_own), .hit_gc(hit_gc)
  );

  tw_rx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .hit_own(hit_own), .hit_gc(hit_gc),
    .busy(busy), .pkt(pkt), .sda_oe(sda_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .addressed(addressed), .xfer_rd(xfer_rd),
    .gc_sel(gc_sel)
  );
endmodule

// File: tb/sim_tw_slave_rx.sv
module sim_tw_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [6:0] own_addr = 7'h2C;
  logic       gc_en = 1'b0;
  logic       busy = 1'b0;
  logic       sda_oe;
  logic [7:0] rx_data;
  logic       rx_valid, addressed, xfer_rd, gc_sel;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  logic [7:0] vlast = '0;
  logic oe_seen;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_slave_rx u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .own_addr(own_addr), .gc_en(gc_en), .busy(busy), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .addressed(addressed),
    .xfer_rd(xfer_rd), .gc_sel(gc_sel)
  );

  always @(negedge clk) if (!rst && rx_valid) begin
    vcnt  = vcnt + 1;
    vlast = rx_data;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    oe_seen = sda_oe;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    // R4: no drive during the eighth bit
    chk(oe_seen, 0, "R4 early drive");
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    ack = (sda_bus == 1'b0);
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
    // R4: released after the ninth bit
    chk(sda_oe, 0, "R4 release");
  endtask

  task automatic t_reset();
    chk(sda_oe, 0, "R13 sda_oe");
    chk(rx_valid, 0, "R13 rx_valid");
    chk({addressed, xfer_rd, gc_sel}, 0, "R13 flags");
  endtask

  task automatic t_write();
    logic a;
    int v0 = vcnt;
    bus_start();
    send_byte({7'h2C, 1'b0}, a);
    chk(a, 1, "R1 R2 own write ack");
    chk({addressed, xfer_rd}, 2'b10, "R2 flags");
    send_byte(8'hA5, a);
    chk(a, 1, "R5 ack first");
    chk(vlast, 8'hA5, "R5 first byte");
    send_byte(8'h3C, a);
    chk(a, 1, "R5 ack second");
    chk(vlast, 8'h3C, "R5 second byte");
    chk(vcnt - v0, 2, "R5 strobe count");
    bus_stop();
    wclk(Q);
    chk({addressed, sda_oe}, 0, "R12 idle after stop");
  endtask

  task automatic t_miss();
    logic a;
    int v0 = vcnt;
    bus_start();
    send_byte({7'h2D, 1'b0}, a);
    chk(a, 0, "R3 other address nack");
    send_byte(8'hFF, a);
    chk(a, 0, "R3 data ignored");
    chk(vcnt - v0, 0, "R3 no byte");
    chk(addressed, 0, "R3 not addressed");
    bus_stop();
  endtask

  task automatic t_gcall();
    logic a;
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, a);
    chk(a, 1, "R6 general call ack");
    chk(gc_sel, 1, "R6 gc_sel");
    send_byte(8'h5A, a);
    chk(a, 1, "R6 data ack");
    chk(vlast, 8'h5A, "R6 data byte");
    bus_stop();
    bus_start();
    send_byte(8'h01, a);
    chk(a, 0, "R7 general call read nack");
    bus_stop();
    gc_en = 1'b0;
    bus_start();
    send_byte(8'h00, a);
    chk(a, 0, "R6 disabled nack");
    chk(gc_sel, 0, "R6 gc_sel low");
    bus_stop();
  endtask

  task automatic t_reserved();
    logic a;
    own_addr = 7'h7A;
    bus_start();
    send_byte({7'h7A, 1'b0}, a);
    chk(a, 0, "R8 reserved nack");
    bus_stop();
    own_addr = 7'h2C;
  endtask

  task automatic t_busy();
    logic a;
    int v0;
    busy = 1'b1;
    bus_start();
    send_byte({7'h2C, 1'b0}, a);
    chk(a, 0, "R9 busy address nack");
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte({7'h2C, 1'b0}, a);
    chk(a, 1, "R9 address ack");
    v0 = vcnt;
    busy = 1'b1;
    send_byte(8'h77, a);
    chk(a, 0, "R9 busy data nack");
    busy = 1'b0;
    send_byte(8'h78, a);
    chk(a, 0, "R9 rest ignored");
    chk(vcnt - v0, 0, "R9 no strobe");
    bus_stop();
  endtask

  task automatic t_read();
    logic a;
    int v0 = vcnt;
    bus_start();
    send_byte({7'h2C, 1'b1}, a);
    chk(a, 1, "R10 read ack");
    chk(xfer_rd, 1, "R10 xfer_rd");
    send_byte(8'h11, a);
    chk(a, 0, "R10 no later ack");
    chk(vcnt - v0, 0, "R10 no byte");
    bus_stop();
  endtask

  task automatic t_rstart();
    logic a;
    bus_start();
    send_byte({7'h2C, 1'b0}, a);
    chk(a, 1, "R11 first address");
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    chk(addressed, 0, "R11 cleared");
    send_byte({7'h2C, 1'b0}, a);
    chk(a, 1, "R11 readdressed");
    send_byte(8'h81, a);
    chk(a, 1, "R11 data ack");
    chk(vlast, 8'h81, "R11 byte after restart");
    bus_stop();
  endtask

  task automatic t_stopmid();
    logic a;
    bus_start();
    send_byte({7'h2C, 1'b0}, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    wclk(Q);
    chk({addressed, sda_oe}, 0, "R12 stop mid byte");
    bus_start();
    send_byte({7'h2C, 1'b0}, a);
    chk(a, 1, "R12 clean restart");
    bus_stop();
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(4);
    t_reset();
    t_write();
    t_miss();
    t_gcall();
    t_reserved();
    t_busy();
    t_read();
    t_rstart();
    t_stopmid();
    wclk(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule